// File: doc/BRIEF.md
# Command Strobe Sequencer for NAND / PC Card Common Memory

This block produces the timed control sequence for a single access to the common memory space of an external NAND flash or 16-bit PC Card style device. One 32-bit timing word holds four 8-bit fields. A host loads the word, chooses the device type and the access direction, and then pulses a start input. The block asserts chip select and address valid and runs a setup phase. It then drives the active-low write or read strobe for a programmed length. If the device holds the active-low wait line low when that length runs out, the strobe stays asserted. The address, and for writes the data, stay valid for a hold phase after the strobe ends.

For write accesses the data bus is left undriven for a programmed number of cycles from the start of the access. After that the bus is driven until the hold phase ends. The device-type input selects between two counting rules. In NAND mode the setup and high-impedance counts are one cycle longer than in PC Card mode. All fields are captured when the access starts, so the host may rewrite the timing word at any time. A one-cycle done pulse marks the return to idle.

Top module: `cmd_strobe_timer`

## Requirements
- R1: The timing word places setup time in bits 7:0, strobe (wait) time in bits 15:8, hold time in bits 23:16 and bus high-impedance time in bits 31:24. After reset the word holds 0xFCFCFCFC.
- R2: The setup phase asserts cs_o with both strobes high. For a setup field S it lasts max(S,1) cycles on a PC Card target (nand_sel_i=0) and S+1 cycles on a NAND target (nand_sel_i=1).
- R3: For a wait-time field W, with wait_ni high, the strobe stays low for W+1 cycles. W=0 is handled as W=1, which gives 2 cycles.
- R4: wait_ni passes through a two-stage synchroniser. If the synchronised value is low when the strobe count expires, the strobe stays low. After wait_ni rises, the strobe is still low at the next two falling clock edges and is high at the third.
- R5: After the strobe deasserts, cs_o stays high for max(H,1) cycles, where H is the hold field.
- R6: On writes, data_oe_o stays low for the first Z cycles of the access on a PC Card target, or Z+1 cycles on a NAND target, where Z is the high-impedance field. It is high from then until the hold phase ends. If the access is shorter, it stays low for the whole access.
- R7: Writes pulse only we_no and reads pulse only oe_no. On reads, data_oe_o never asserts and the high-impedance field has no effect.
- R8: done_o is high for exactly one cycle, in the first cycle in which cs_o is low after an access.
- R9: Timing fields, device type and direction are captured when the access starts. A timing-word write or a start pulse during an access does not change that access. The written word does apply to the next access.
- R10: While reset is asserted and after reset, cs_o, data_oe_o, done_o and busy_o are 0 and we_no and oe_no are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tim_we_i | input | 1 | Load strobe for the timing word |
| tim_wdata_i | input | 32 | New timing word |
| nand_sel_i | input | 1 | 1 selects NAND counting, 0 selects PC Card counting |
| start_i | input | 1 | Starts an access when idle |
| write_i | input | 1 | Access direction, 1 means write |
| wait_ni | input | 1 | Device wait request, active low, asynchronous |
| busy_o | output | 1 | An access is in progress |
| cs_o | output | 1 | Chip select / address valid |
| we_no | output | 1 | Write strobe, active low |
| oe_no | output | 1 | Read strobe, active low |
| data_oe_o | output | 1 | Drive the data bus |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach is the strobe extension, because the wait line must already be low at the synchronised input when the programmed count expires. The bench therefore drives wait_ni low before it starts an access with a short strobe field. It confirms that the strobe outlasts its programmed length by many cycles. It then releases the line and counts the falling edges until the strobe deasserts. The bench also writes a new timing word and pulses start in the middle of an access. It checks that the running access keeps its original counts and that the following access uses the new word.

// File: rtl/strobe_pkg.sv
package strobe_pkg;
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_SETUP = 3'd1,
    PH_STRB  = 3'd2,
    PH_WEXT  = 3'd3,
    PH_HOLD  = 3'd4
  } phase_e;
endpackage

// File: rtl/strobe_timing_reg.sv
module strobe_timing_reg #(
  parameter int          FIELD_W    = 8,
  parameter int          CNT_W      = FIELD_W + 1,
  parameter logic [4*FIELD_W-1:0] RESET_WORD = 32'hFCFC_FCFC
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [4*FIELD_W-1:0] wdata_i,
  input  logic                 nand_i,
  output logic [CNT_W-1:0]     setup_len_o,
  output logic [CNT_W-1:0]     strobe_len_o,
  output logic [CNT_W-1:0]     hold_len_o,
  output logic [CNT_W-1:0]     hiz_len_o
);
  localparam int WORD_W = 4 * FIELD_W;

  logic [WORD_W-1:0]  word_q;
  logic [FIELD_W-1:0] f_setup, f_wait, f_hold, f_hiz;
  logic [CNT_W-1:0]   setup_raw, wait_eff;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   word_q <= RESET_WORD;
    else if (we_i) word_q <= wdata_i;
  end

  assign f_setup = word_q[FIELD_W-1:0];
  assign f_wait  = word_q[2*FIELD_W-1:FIELD_W];
  assign f_hold  = word_q[3*FIELD_W-1:2*FIELD_W];
  assign f_hiz   = word_q[4*FIELD_W-1:3*FIELD_W];

  always_comb begin
    setup_raw    = {1'b0, f_setup} + {{(CNT_W-1){1'b0}}, nand_i};
    setup_len_o  = (setup_raw == '0) ? CNT_W'(1) : setup_raw;
    // reserved zero treated as one
    wait_eff     = (f_wait == '0) ? CNT_W'(1) : {1'b0, f_wait};
    strobe_len_o = wait_eff + CNT_W'(1);
    hold_len_o   = (f_hold == '0) ? CNT_W'(1) : {1'b0, f_hold};
    hiz_len_o    = {1'b0, f_hiz} + {{(CNT_W-1){1'b0}}, nand_i};
  end
endmodule

// File: rtl/strobe_wait_sync.sv
module strobe_wait_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '1;
    else         sh_q <= {sh_q[STAGES-2:0], async_i};
  end

  assign sync_o = sh_q[STAGES-1];
endmodule

// File: rtl/strobe_phase_fsm.sv
module strobe_phase_fsm
  import strobe_pkg::*;
#(
  parameter int CNT_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             launch_i,
  input  logic             write_i,
  input  logic [CNT_W-1:0] setup_len_i,
  input  logic [CNT_W-1:0] strobe_len_i,
  input  logic [CNT_W-1:0] hold_len_i,
  input  logic             wait_s_i,
  output logic             busy_o,
  output logic             wr_o,
  output logic             cs_o,
  output logic             we_no,
  output logic             oe_no,
  output logic             done_o
);
  phase_e           ph_q;
  logic [CNT_W-1:0] cnt_q, strobe_l_q, hold_l_q;
  logic             wr_q, done_q, strb_act;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q       <= PH_IDLE;
      cnt_q      <= '0;
      strobe_l_q <= '0;
      hold_l_q   <= '0;
      wr_q       <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (ph_q)
        PH_IDLE: if (launch_i) begin
          wr_q       <= write_i;
          strobe_l_q <= strobe_len_i;
          hold_l_q   <= hold_len_i;
          cnt_q      <= setup_len_i - CNT_W'(1);
          ph_q       <= PH_SETUP;
        end
        PH_SETUP: if (cnt_q == '0) begin
          cnt_q <= strobe_l_q - CNT_W'(1);
          ph_q  <= PH_STRB;
        end else cnt_q <= cnt_q - CNT_W'(1);
        PH_STRB: if (cnt_q == '0) begin
          if (wait_s_i) begin
            cnt_q <= hold_l_q - CNT_W'(1);
            ph_q  <= PH_HOLD;
          end else ph_q <= PH_WEXT;
        end else cnt_q <= cnt_q - CNT_W'(1);
        PH_WEXT: if (wait_s_i) begin
          cnt_q <= hold_l_q - CNT_W'(1);
          ph_q  <= PH_HOLD;
        end
        PH_HOLD: if (cnt_q == '0) begin
          ph_q   <= PH_IDLE;
          done_q <= 1'b1;
        end else cnt_q <= cnt_q - CNT_W'(1);
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assign strb_act = (ph_q == PH_STRB) || (ph_q == PH_WEXT);
  assign busy_o   = (ph_q != PH_IDLE);
  assign cs_o     = busy_o;
  assign wr_o     = wr_q;
  assign we_no    = ~(strb_act & wr_q);
  assign oe_no    = ~(strb_act & ~wr_q);
  assign done_o   = done_q;

  // R4
  wait_ext_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == PH_WEXT && !wait_s_i) |=> (ph_q == PH_WEXT));
  // R5
  hold_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == PH_HOLD && $past(ph_q) != PH_HOLD) |-> ($past(ph_q) == PH_STRB || $past(ph_q) == PH_WEXT));
  // R7
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) !(!we_no && !oe_no));
  // R8
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) done_o |=> !done_o);
  // R8
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) done_o |-> !cs_o);
endmodule

// File: rtl/strobe_hiz_timer.sv
module strobe_hiz_timer #(
  parameter int CNT_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             launch_i,
  input  logic [CNT_W-1:0] hiz_len_i,
  input  logic             busy_i,
  input  logic             wr_i,
  output logic             data_oe_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (launch_i)     cnt_q <= hiz_len_i;
    else if (cnt_q != '0)  cnt_q <= cnt_q - CNT_W'(1);
  end

  assign data_oe_o = busy_i & wr_i & (cnt_q == '0);

  // R7
  rd_no_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !wr_i) |-> !data_oe_o);
  // R6
  drive_stays_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_oe_o && busy_i) |=> (data_oe_o || !busy_i));
endmodule

// File: rtl/cmd_strobe_timer.sv
module cmd_strobe_timer #(
  parameter int FIELD_W     = 8,
  parameter int SYNC_STAGES = 2,
  parameter logic [4*FIELD_W-1:0] RESET_WORD = 32'hFCFC_FCFC
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 tim_we_i,
  input  logic [4*FIELD_W-1:0] tim_wdata_i,
  input  logic                 nand_sel_i,
  input  logic                 start_i,
  input  logic                 write_i,
  input  logic                 wait_ni,
  output logic                 busy_o,
  output logic                 cs_o,
  output logic                 we_no,
  output logic                 oe_no,
  output logic                 data_oe_o,
  output logic                 done_o
);
  localparam int CNT_W = FIELD_W + 1;

  logic [CNT_W-1:0] setup_len, strobe_len, hold_len, hiz_len;
  logic             wait_s, launch, busy, wr;

  assign launch = start_i & ~busy;
  assign busy_o = busy;

  strobe_timing_reg #(.FIELD_W(FIELD_W), .CNT_W(CNT_W), .RESET_WORD(RESET_WORD)) u_reg (
    .clk_i, .rst_ni,
    .we_i(tim_we_i), .wdata_i(tim_wdata_i), .nand_i(nand_sel_i),
    .setup_len_o(setup_len), .strobe_len_o(strobe_len),
    .hold_len_o(hold_len), .hiz_len_o(hiz_len)
  );

  strobe_wait_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .async_i(wait_ni), .sync_o(wait_s)
  );

  strobe_phase_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk_i, .rst_ni, .launch_i(launch), .write_i(write_i),
    .setup_len_i(setup_len), .strobe_len_i(strobe_len), .hold_len_i(hold_len),
    .wait_s_i(wait_s), .busy_o(busy), .wr_o(wr), .cs_o(cs_o),
    .we_no(we_no), .oe_no(oe_no), .done_o(done_o)
  );

  strobe_hiz_timer #(.CNT_W(CNT_W)) u_hiz (
    .clk_i, .rst_ni, .launch_i(launch), .hiz_len_i(hiz_len),
    .busy_i(busy), .wr_i(wr), .data_oe_o(data_oe_o)
  );

  // R2
  strobe_in_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_no || !oe_no) |-> cs_o);
endmodule

// File: tb/sim_cmd_strobe_timer.sv
module sim_cmd_strobe_timer;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tim_we_i = 1'b0;
  logic [31:0] tim_wdata_i = '0;
  logic        nand_sel_i = 1'b0;
  logic        start_i = 1'b0;
  logic        write_i = 1'b0;
  logic        wait_ni = 1'b1;
  logic        busy_o, cs_o, we_no, oe_no, data_oe_o, done_o;

  int n_chk = 0;
  int n_fail = 0;
  logic ended = 1'b0;

  always #10 clk = ~clk;

  cmd_strobe_timer u0 (
    .clk_i(clk), .rst_ni, .tim_we_i, .tim_wdata_i, .nand_sel_i, .start_i,
    .write_i, .wait_ni, .busy_o, .cs_o, .we_no, .oe_no, .data_oe_o, .done_o
  );

  typedef struct packed {
    logic [7:0]  s, w, h, z;
    logic        nd, wr;
    logic [15:0] es, est, eh, ez;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{8'd2, 8'd3, 8'd2, 8'd1,   1'b0, 1'b1, 16'd2, 16'd4, 16'd2, 16'd1},
    '{8'd2, 8'd3, 8'd2, 8'd1,   1'b1, 1'b1, 16'd3, 16'd4, 16'd2, 16'd2},
    '{8'd0, 8'd0, 8'd0, 8'd0,   1'b0, 1'b1, 16'd1, 16'd2, 16'd1, 16'd0},
    '{8'd0, 8'd0, 8'd0, 8'd0,   1'b1, 1'b1, 16'd1, 16'd2, 16'd1, 16'd1},
    '{8'd1, 8'd1, 8'd1, 8'd5,   1'b0, 1'b0, 16'd1, 16'd2, 16'd1, 16'd0},
    '{8'd4, 8'd2, 8'd3, 8'd20,  1'b1, 1'b1, 16'd5, 16'd3, 16'd3, 16'd11},
    '{8'd3, 8'd5, 8'd4, 8'd255, 1'b1, 1'b0, 16'd4, 16'd6, 16'd4, 16'd0},
    '{8'd0, 8'd1, 8'd1, 8'd0,   1'b1, 1'b1, 16'd1, 16'd2, 16'd1, 16'd1}
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_access(input logic ld, input logic [31:0] word, input logic nd,
                           input logic wr, input logic mid,
                           output int ns, output int nst, output int nh, output int nz,
                           output int noe, output int ndone,
                           output logic used_we, output logic used_oe);
    int cyc;
    logic seen, seen_oe;
    ns = 0; nst = 0; nh = 0; nz = 0; noe = 0; ndone = 0;
    used_we = 1'b0; used_oe = 1'b0; seen = 1'b0; seen_oe = 1'b0; cyc = 0;
    @(negedge clk);
    if (ld) begin
      tim_we_i = 1'b1; tim_wdata_i = word;
      @(negedge clk);
      tim_we_i = 1'b0;
    end
    nand_sel_i = nd; write_i = wr; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    while (cs_o && cyc < 2000) begin
      if (!we_no || !oe_no) begin
        nst++; seen = 1'b1;
        if (!we_no) used_we = 1'b1;
        if (!oe_no) used_oe = 1'b1;
      end else if (!seen) ns++;
      else nh++;
      if (data_oe_o) begin noe++; seen_oe = 1'b1; end
      else if (!seen_oe) nz++;
      if (done_o) ndone++;
      if (mid && cyc == 1) begin
        tim_we_i = 1'b1; tim_wdata_i = 32'h0101_0101; start_i = 1'b1; nand_sel_i = ~nd;
      end
      if (mid && cyc == 2) begin
        tim_we_i = 1'b0; start_i = 1'b0; nand_sel_i = nd;
      end
      cyc++;
      @(negedge clk);
    end
    if (done_o) ndone++;
    @(negedge clk);
    if (done_o) ndone++;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!ended) begin
      ended = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int ns, nst, nh, nz, noe, nd;
    logic uw, uo;
    repeat (3) @(negedge clk);
    // R10 during reset
    check("R10 cs in reset", int'(cs_o), 0);
    check("R10 we_no in reset", int'(we_no), 1);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R10 cs", int'(cs_o), 0);
    check("R10 we_no", int'(we_no), 1);
    check("R10 oe_no", int'(oe_no), 1);
    check("R10 data_oe", int'(data_oe_o), 0);
    check("R10 done", int'(done_o), 0);
    check("R10 busy", int'(busy_o), 0);

    // R1: reset word 0xFCFCFCFC, PC Card write
    do_access(1'b0, '0, 1'b0, 1'b1, 1'b0, ns, nst, nh, nz, noe, nd, uw, uo);
    check("R1 setup", ns, 252);
    check("R1 strobe", nst, 253);
    check("R1 hold", nh, 252);
    check("R1 hiz", nz, 252);
    check("R1 drive", noe, 505);
    check("R8 done", nd, 1);

    for (int i = 0; i < NV; i++) begin
      do_access(1'b1, {VEC[i].z, VEC[i].h, VEC[i].w, VEC[i].s}, VEC[i].nd, VEC[i].wr, 1'b0,
                ns, nst, nh, nz, noe, nd, uw, uo);
      check($sformatf("R2 setup v%0d", i), ns, int'(VEC[i].es));
      check($sformatf("R3 strobe v%0d", i), nst, int'(VEC[i].est));
      check($sformatf("R5 hold v%0d", i), nh, int'(VEC[i].eh));
      check($sformatf("R8 done v%0d", i), nd, 1);
      check($sformatf("R7 strobe kind v%0d", i), {uw, uo}, VEC[i].wr ? 2 : 1);
      if (VEC[i].wr) check($sformatf("R6 hiz v%0d", i), nz, int'(VEC[i].ez));
      else           check($sformatf("R7 read no drive v%0d", i), noe, 0);
    end

    // R9: rewrite and restart during an access
    do_access(1'b1, 32'h0102_0302, 1'b0, 1'b1, 1'b1, ns, nst, nh, nz, noe, nd, uw, uo);
    check("R9 setup kept", ns, 2);
    check("R9 strobe kept", nst, 4);
    check("R9 hold kept", nh, 2);
    check("R9 hiz kept", nz, 1);
    check("R9 single done", nd, 1);
    check("R9 idle after", int'(cs_o), 0);
    do_access(1'b0, '0, 1'b0, 1'b1, 1'b0, ns, nst, nh, nz, noe, nd, uw, uo);
    check("R9 new word setup", ns, 1);
    check("R9 new word strobe", nst, 2);
    check("R9 new word hiz", nz, 1);

    // R4: wait extension
    @(negedge clk);
    tim_we_i = 1'b1; tim_wdata_i = 32'h0002_0101;
    @(negedge clk);
    tim_we_i = 1'b0; wait_ni = 1'b0; nand_sel_i = 1'b0; write_i = 1'b0; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    while (oe_no) @(negedge clk);
    repeat (30) @(negedge clk);
    check("R4 strobe held", int'(oe_no), 0);
    wait_ni = 1'b1;
    nst = 0;
    @(negedge clk);
    while (!oe_no && nst < 50) begin nst++; @(negedge clk); end
    check("R4 release latency", nst, 2);
    nh = 0;
    while (cs_o && nh < 50) begin nh++; @(negedge clk); end
    check("R5 hold after extend", nh, 2);
    check("R8 done after extend", int'(done_o), 1);

    ended = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule